// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the host-facing register set of a four-channel DMA controller, reached over an 8-bit I/O port bus, together with a small transfer engine for each channel. The host programs a 16-bit current address, a 16-bit count and an 8-bit page per channel. It also writes a mode byte and a mask state per channel. Address and count are 16 bits wide but share one byte-wide port each. A single internal low/high byte pointer decides which half a byte access reaches.

Once a channel is unmasked and programmed for single-transfer mode, every rising request from the device side earns one grant. During that grant the block drives the 24-bit memory address and the direction, steps the address and counts down. After the last transfer it signals end of process, latches a terminal-count flag and masks the channel. Page bits never change during a transfer, so a run stays inside one 64 KiB window.

Top module: `quad_dma_front`

## Requirements
- R1: Each 16-bit address or count register is reached through one port (address of channel n at port n, count of channel n at port 4+n). Each access, read or write, reaches the low byte when the byte pointer is 0 and the high byte when it is 1, then toggles the pointer. Reads return the current value.
- R2: Any write to port 11 clears the byte pointer, so the next address or count access reaches the low byte.
- R3: A count programmed as N-1 yields exactly N transfers before terminal count. The count wraps from 0 to 0xFFFF and reads back as 0xFFFF afterwards.
- R4: During a grant, `mem_addr` equals {page, current address}. The address then increments modulo 2^16, and the page (ports 16 to 19, readable) is left unchanged.
- R5: A write to port 10 stores a mode for the channel in bits 1:0. Bits 3:2 give the transfer type: 01 moves data to memory (`to_mem`=1) and 10 moves data from memory (`to_mem`=0). Bits 7:6 give the mode: 01 is single transfer and 11 is cascade. Only single mode with type 01 or 10 ever transfers.
- R6: A write to port 9 masks the channel in bits 1:0 when bit 2 is 1 and unmasks it when bit 2 is 0. A masked channel gets no grant.
- R7: An eligible channel with its request high gets `dack` for exactly one cycle per transfer. At most one `dack` bit is high at a time, and a cycle with no grant always follows a grant.
- R8: On the grant whose count was 0, `eop` is high together with `dack`. The channel's terminal-count flag is set and the channel masks itself.
- R9: A read of port 8 returns the terminal-count flags in bits 3:0 and the live request levels in bits 7:4. The read clears the flags that were set before it.
- R10: Reset, or any write to port 12, clears every register, the byte pointer and the outputs, and masks all channels.
- R11: Any write to port 13 unmasks all four channels.
- R12: When several eligible channels request at once, the lowest-numbered one is granted.
- R13: Reads of unassigned ports return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Port access strobe, one cycle per access |
| io_wr | input | 1 | 1 for write, 0 for read |
| io_addr | input | 5 | Port number |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port |
| dreq | input | 4 | Device requests, one per channel |
| dack | output | 4 | Grant, one-hot, one cycle per transfer |
| mem_addr | output | 24 | Memory address of the granted transfer |
| to_mem | output | 1 | Direction of the granted transfer |
| eop | output | 1 | End of process, high with the final grant |

## Verification
The assertions take for granted that each port access lasts one `io_sel` cycle with stable address and data, and that requests may change at any cycle. Self-masking and priority are judged only against the mask state of the previous cycle. The stimulus drives every input on the falling edge and issues at most one access per cycle. It avoids writing a channel's registers in the same cycle that channel is granted, and keeps requests high long enough for the count to run out and the self-mask to take hold.

// File: rtl/qd_pkg.sv
package qd_pkg;
    localparam int NCH  = 4;
    localparam int CHW  = $clog2(NCH);
    localparam int AW   = 16;
    localparam int PW   = 8;
    localparam int DW   = 8;
    localparam int IOAW = 5;
    localparam int MW   = DW - 2;

    localparam logic [1:0] MD_SINGLE  = 2'b01;
    localparam logic [1:0] TT_TOMEM   = 2'b01;
    localparam logic [1:0] TT_FROMMEM = 2'b10;

    typedef enum logic [3:0] {
        PK_NONE, PK_ADDR, PK_CNT, PK_PAGE, PK_STAT,
        PK_MASK, PK_MODE, PK_CLRPTR, PK_MCLR, PK_CLRMASK
    } port_kind_e;

    typedef struct packed {
        logic [NCH-1:0][AW-1:0] addr;
        logic [NCH-1:0][AW-1:0] cnt;
        logic [NCH-1:0][PW-1:0] page;
        logic [NCH-1:0][MW-1:0] mode;
        logic [NCH-1:0]         mask;
        logic [NCH-1:0]         tc;
        logic                   ptr;
        logic [NCH-1:0]         dack;
        logic [PW+AW-1:0]       maddr;
        logic                   dir;
        logic                   eop;
    } st_t;
endpackage

// File: rtl/qd_port_decode.sv
module qd_port_decode
    import qd_pkg::*;
(
    input  logic [IOAW-1:0] io_addr,
    output port_kind_e      kind,
    output logic [CHW-1:0]  ch
);
    always_comb begin
        kind = PK_NONE;
        ch   = io_addr[CHW-1:0];
        if (io_addr[4]) begin
            if (io_addr[3:2] == 2'b00) kind = PK_PAGE;
        end else begin
            unique case (io_addr[3:2])
                2'b00: kind = PK_ADDR;
                2'b01: kind = PK_CNT;
                2'b10: begin
                    unique case (io_addr[1:0])
                        2'd0: kind = PK_STAT;
                        2'd1: kind = PK_MASK;
                        2'd2: kind = PK_MODE;
                        default: kind = PK_CLRPTR;
                    endcase
                end
                default: begin
                    if (io_addr[1:0] == 2'd0)      kind = PK_MCLR;
                    else if (io_addr[1:0] == 2'd1) kind = PK_CLRMASK;
                end
            endcase
        end
    end
endmodule

// File: rtl/qd_prio_pick.sv
module qd_prio_pick #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/quad_dma_front.sv
module quad_dma_front
    import qd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [IOAW-1:0]   io_addr,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic [PW+AW-1:0]  mem_addr,
    output logic              to_mem,
    output logic              eop
);
    st_t q, d;

    function automatic st_t clr_state();
        st_t s;
        s      = '0;
        s.mask = '1;
        return s;
    endfunction

    port_kind_e       kind;
    logic [CHW-1:0]   pch;
    logic [NCH-1:0]   elig, gnt;
    logic [CHW-1:0]   gidx;
    logic             gany;
    logic [NCH-1:0]   mask_w, tc_w;

    qd_port_decode u_dec (.io_addr(io_addr), .kind(kind), .ch(pch));

    for (genvar i = 0; i < NCH; i++) begin : g_elig
        assign elig[i] = !q.mask[i] && dreq[i] && (q.mode[i][MW-1:MW-2] == MD_SINGLE)
                       && ((q.mode[i][1:0] == TT_TOMEM) || (q.mode[i][1:0] == TT_FROMMEM));
    end

    qd_prio_pick #(.N(NCH)) u_pick (
        .req (elig & {NCH{~|q.dack}}),
        .gnt (gnt),
        .idx (gidx),
        .any (gany)
    );

    always_comb begin
        d      = q;
        d.dack = '0;
        d.eop  = 1'b0;
        if (gany) begin
            d.dack       = gnt;
            d.maddr      = {q.page[gidx], q.addr[gidx]};
            d.dir        = (q.mode[gidx][1:0] == TT_TOMEM);
            d.addr[gidx] = q.addr[gidx] + 1'b1;
            d.cnt[gidx]  = q.cnt[gidx] - 1'b1;
            if (q.cnt[gidx] == '0) begin
                d.tc[gidx]   = 1'b1;
                d.mask[gidx] = 1'b1;
                d.eop        = 1'b1;
            end
        end
        if (io_sel) begin
            unique case (kind)
                PK_ADDR: begin
                    if (io_wr) begin
                        if (q.ptr) d.addr[pch][AW-1:DW] = io_wdata;
                        else       d.addr[pch][DW-1:0]  = io_wdata;
                    end
                    d.ptr = ~q.ptr;
                end
                PK_CNT: begin
                    if (io_wr) begin
                        if (q.ptr) d.cnt[pch][AW-1:DW] = io_wdata;
                        else       d.cnt[pch][DW-1:0]  = io_wdata;
                    end
                    d.ptr = ~q.ptr;
                end
                PK_PAGE:    if (io_wr)  d.page[pch] = io_wdata;
                PK_STAT:    if (!io_wr) d.tc = d.tc & ~q.tc;
                PK_MASK:    if (io_wr)  d.mask[io_wdata[CHW-1:0]] = io_wdata[2];
                PK_MODE:    if (io_wr)  d.mode[io_wdata[CHW-1:0]] = io_wdata[DW-1:2];
                PK_CLRPTR:  if (io_wr)  d.ptr = 1'b0;
                PK_MCLR:    if (io_wr)  d = clr_state();
                PK_CLRMASK: if (io_wr)  d.mask = '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= clr_state();
        else        q <= d;
    end

    always_comb begin
        io_rdata = '0;
        unique case (kind)
            PK_ADDR: io_rdata = q.ptr ? q.addr[pch][AW-1:DW] : q.addr[pch][DW-1:0];
            PK_CNT:  io_rdata = q.ptr ? q.cnt[pch][AW-1:DW]  : q.cnt[pch][DW-1:0];
            PK_PAGE: io_rdata = q.page[pch];
            PK_STAT: io_rdata = {dreq, q.tc};
            default: io_rdata = '0;
        endcase
    end

    assign dack     = q.dack;
    assign mem_addr = q.maddr;
    assign to_mem   = q.dir;
    assign eop      = q.eop;
    assign mask_w   = q.mask;
    assign tc_w     = q.tc;
endmodule

// File: rtl/qd_checker.sv
module qd_checker
    import qd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            io_sel,
    input logic            io_wr,
    input logic [IOAW-1:0] io_addr,
    input logic [NCH-1:0]  dack,
    input logic            eop,
    input logic [NCH-1:0]  mask_q,
    input logic [NCH-1:0]  tc_q
);
    a_r7_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    a_r7_idle_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |=> (dack == '0));

    a_r8_eop_sets_tc_and_mask: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> ((dack != '0) && ((dack & tc_q) == dack) && ((dack & mask_q) == dack)));

    a_r6_masked_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (dack & $past(mask_q)) == '0);

    a_r10_mclr_masks_all: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_wr && io_addr == IOAW'(12)) |=> (mask_q == '1 && dack == '0 && tc_q == '0));
endmodule

bind quad_dma_front qd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_sel  (io_sel),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .dack    (dack),
    .eop     (eop),
    .mask_q  (mask_w),
    .tc_q    (tc_w)
);

// File: tb/quad_dma_front_tb.sv
module quad_dma_front_tb;
    import qd_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, io_sel = 1'b0, io_wr = 1'b0;
    logic [IOAW-1:0] io_addr = '0;
    logic [DW-1:0] io_wdata = '0, io_rdata;
    logic [NCH-1:0] dreq = '0, dack;
    logic [PW+AW-1:0] mem_addr;
    logic to_mem, eop;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_dma_front u_dut (.clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq),
        .dack(dack), .mem_addr(mem_addr), .to_mem(to_mem), .eop(eop));

    int n_cmp = 0, n_bad = 0;
    bit cmp_on = 0, done = 0;

    // behavioural model
    int m_addr[4], m_cnt[4], m_page[4], m_mode[4];
    int m_mask, m_tc, m_ptr, m_dack, m_eop, m_dir, m_maddr;

    task automatic mreset();
        for (int i = 0; i < 4; i++) begin
            m_addr[i] = 0; m_cnt[i] = 0; m_page[i] = 0; m_mode[i] = 0;
        end
        m_mask = 15; m_tc = 0; m_ptr = 0; m_dack = 0; m_eop = 0; m_dir = 0; m_maddr = 0;
    endtask

    function automatic int bput(int v, int w);
        return m_ptr ? ((v & 'hFF) | (w << 8)) : ((v & 'hFF00) | w);
    endfunction

    task automatic mstep();
        int g, t, a, c, tc_old;
        g = -1; tc_old = m_tc;
        if (m_dack == 0)
            for (int i = 3; i >= 0; i--) begin
                t = m_mode[i] & 3;
                if (((m_mask >> i) & 1) == 0 && dreq[i] && (m_mode[i] >> 4) == 1 && (t == 1 || t == 2))
                    g = i;
            end
        m_dack = 0; m_eop = 0;
        if (g >= 0) begin
            m_dack  = 1 << g;
            m_maddr = (m_page[g] << 16) | m_addr[g];
            m_dir   = ((m_mode[g] & 3) == 1);
            m_addr[g] = (m_addr[g] + 1) & 'hFFFF;
            if (m_cnt[g] == 0) begin
                m_tc |= 1 << g; m_mask |= 1 << g; m_eop = 1;
            end
            m_cnt[g] = (m_cnt[g] - 1) & 'hFFFF;
        end
        if (io_sel) begin
            a = int'(io_addr); c = a & 3;
            if (a < 8) begin
                if (io_wr) begin
                    if (a < 4) m_addr[c] = bput(m_addr[c], int'(io_wdata));
                    else       m_cnt[c]  = bput(m_cnt[c], int'(io_wdata));
                end
                m_ptr ^= 1;
            end else if (a >= 16 && a < 20) begin
                if (io_wr) m_page[c] = int'(io_wdata);
            end else if (a == 8) begin
                if (!io_wr) m_tc &= ~tc_old;
            end else if (io_wr) begin
                case (a)
                    9:  if (io_wdata[2]) m_mask |= 1 << (io_wdata & 3);
                        else             m_mask &= ~(1 << (io_wdata & 3));
                    10: m_mode[io_wdata & 3] = int'(io_wdata) >> 2;
                    11: m_ptr = 0;
                    12: mreset();
                    13: m_mask = 0;
                    default: ;
                endcase
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) mreset();
        else mstep();
    end

    function automatic int exp_rd(int a);
        if (a < 4)  return m_ptr ? (m_addr[a] >> 8) : (m_addr[a] & 'hFF);
        if (a < 8)  return m_ptr ? (m_cnt[a-4] >> 8) : (m_cnt[a-4] & 'hFF);
        if (a == 8) return (int'(dreq) << 4) | m_tc;
        if (a >= 16 && a < 20) return m_page[a-16];
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act %0h exp %0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    int dq_addr[$], dq_ch[$], dq_eop[$], dq_dir[$];
    always @(negedge clk) begin
        #1;
        if (cmp_on && !done) begin
            chk("R7 dack", int'(dack), m_dack);
            chk("R8 eop", int'(eop), m_eop);
            chk("R4 mem_addr", int'(mem_addr), m_maddr);
            chk("R5 to_mem", int'(to_mem), m_dir);
            if (io_sel && !io_wr) chk("R1 io_rdata", int'(io_rdata), exp_rd(int'(io_addr)));
            if (dack != 0) begin
                dq_addr.push_back(int'(mem_addr)); dq_ch.push_back(int'(dack));
                dq_eop.push_back(int'(eop));       dq_dir.push_back(int'(to_mem));
            end
        end
    end

    task automatic qclr();
        dq_addr.delete(); dq_ch.delete(); dq_eop.delete(); dq_dir.delete();
    endtask

    task automatic wr(int a, int v);
        io_sel = 1; io_wr = 1; io_addr = IOAW'(a); io_wdata = DW'(v);
        @(negedge clk);
        io_sel = 0; io_wr = 0;
    endtask

    task automatic rd(int a, output int v);
        io_sel = 1; io_wr = 0; io_addr = IOAW'(a);
        #2 v = int'(io_rdata);
        @(negedge clk);
        io_sel = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1; n_bad++;
            $display("FAIL watchdog all requirements act 0 exp 1");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1; cmp_on = 1;
        chk("R10 reset dack", int'(dack), 0);
        rd(8, v);  chk("R10 reset status", v, 0);
        rd(0, v);  chk("R10 reset address", v, 0);

        // ch1: address 0xFFFE, page 0x34, count 2 (three transfers)
        wr(11, 0);
        wr(1, 'hFE); wr(1, 'hFF);
        wr(5, 2);    wr(5, 0);
        wr(17, 'h34);
        wr(11, 0);
        rd(1, v); chk("R1 address low byte", v, 'hFE);
        rd(1, v); chk("R1 address high byte", v, 'hFF);
        wr(10, 'h45);
        qclr();
        wr(9, 'h01);
        dreq = 4'b0010;
        idle(12);
        chk("R3 transfer count", dq_addr.size(), 3);
        if (dq_addr.size() == 3) begin
            chk("R4 first address", dq_addr[0], 'h34FFFE);
            chk("R4 second address", dq_addr[1], 'h34FFFF);
            chk("R4 wrap keeps page", dq_addr[2], 'h340000);
            chk("R8 eop on last", dq_eop[2], 1);
            chk("R8 no early eop", dq_eop[0] | dq_eop[1], 0);
            chk("R5 direction to memory", dq_dir[0], 1);
        end
        rd(8, v); chk("R9 status flags and dreq", v, 'h22);
        rd(8, v); chk("R9 flags cleared by read", v, 'h20);
        wr(11, 0);
        rd(5, v); chk("R3 count wrapped low", v, 'hFF);
        rd(5, v); chk("R3 count wrapped high", v, 'hFF);
        dreq = 4'b0000;

        // byte pointer clear
        wr(11, 0); wr(0, 'hAA); wr(11, 0); wr(0, 'h11); wr(0, 'h22); wr(11, 0);
        rd(0, v); chk("R2 low after pointer clear", v, 'h11);
        rd(0, v); chk("R2 high after pointer clear", v, 'h22);

        // priority and clear-mask
        wr(12, 0);
        wr(10, 'h44); wr(10, 'h46);
        wr(4, 4); wr(4, 0); wr(6, 4); wr(6, 0);
        wr(13, 0);
        qclr();
        dreq = 4'b0101;
        idle(4);
        chk("R11 clear-mask enables transfers", int'(dq_ch.size() > 0), 1);
        if (dq_ch.size() > 0) chk("R12 channel 0 wins", dq_ch[0], 1);
        dreq = 4'b0100;
        idle(1);
        qclr();
        idle(4);
        if (dq_ch.size() > 0) chk("R12 channel 2 after 0 drops", dq_ch[0], 4);
        else chk("R12 channel 2 granted", 0, 1);
        dreq = 4'b0000;

        // cascade and read direction on ch3
        wr(11, 0); wr(7, 'h10); wr(7, 0);
        wr(10, 'hC7); wr(9, 3);
        qclr();
        dreq = 4'b1000;
        idle(8);
        chk("R5 cascade never granted", dq_ch.size(), 0);
        wr(10, 'h4B);
        idle(4);
        chk("R5 single mode grants", int'(dq_ch.size() > 0), 1);
        if (dq_dir.size() > 0) chk("R5 direction from memory", dq_dir[0], 0);

        // single mask
        wr(9, 'h07);
        idle(2);
        qclr();
        idle(6);
        chk("R6 masked channel idle", dq_ch.size(), 0);
        wr(9, 3);
        qclr();
        idle(4);
        chk("R6 unmasked channel runs", int'(dq_ch.size() > 0), 1);

        // master clear
        wr(12, 0);
        dreq = 4'hF;
        qclr();
        idle(4);
        chk("R10 master clear masks all", dq_ch.size(), 0);
        rd(3, v);  chk("R10 address cleared", v, 0);
        rd(3, v);  chk("R10 address high cleared", v, 0);
        rd(19, v); chk("R10 page cleared", v, 0);
        dreq = 4'h0;

        rd(14, v); chk("R13 unassigned port", v, 0);
        rd(21, v); chk("R13 unassigned page slot", v, 0);
        idle(2);

        done = 1;
        summary();
        $finish;
    end
endmodule